// File: doc/BRIEF.md
# Dual-Channel Debug Mailbox

This block moves short messages in both directions between an on-chip CPU register bus and an external debug access port. The debug side deposits words into two incoming mailbox registers that the CPU picks up, and the CPU places words into two outgoing mailbox registers that the debug side collects. A handshake flag beside each mailbox tells each side whether the other has consumed or supplied data, so both sides can poll without losing or repeating a message.

The CPU reaches five word-addressed locations through a synchronous bus with byte enables: a control/status register at address 0, incoming channels 0 and 1 at addresses 1 and 2, and outgoing channels 0 and 1 at addresses 3 and 4. CPU read data is combinational on the addressed location, and a read's side effect takes place at the clock edge that ends the request. The debug side has its own synchronous port with a request, a write strobe, a channel select and a double-width data path. A wide-mode bit in the control register pairs the two channels into one double-width transfer. The four flags are also brought out as pins so that outside logic can raise interrupts from them.

Top module: `dbg_mbox`

## Requirements
- R1: After reset the control register reads 0x000C: both outgoing ready flags (bits 3 and 2, channels 1 and 0) are 1, both incoming new-data flags (bits 1 and 0) are 0, and every mailbox register reads 0.
- R2: Control bits 15 to 8 and bit 5 always read 0. Bit 7 (channel 1 hold), bit 6 (channel 0 hold) and bit 4 (wide mode) are written from the low byte. The ready flags in bits 3 and 2 ignore CPU writes.
- R3: A CPU write to an outgoing register updates only the bytes whose enables are set. The channel's ready flag goes to 0 when the upper-byte enable is set, and it keeps its value when only the lower byte is written or no byte is enabled.
- R4: A debug read of an outgoing channel returns its contents and sets that channel's ready flag one cycle later. When a CPU write that clears the flag lands in the same cycle, the flag ends at 0.
- R5: A debug write stores the low half of the debug data into the selected incoming register and sets its new-data flag. A CPU read of that register returns the stored value.
- R6: When a channel's hold bit is 0, a CPU read of that incoming register clears its new-data flag.
- R7: When a channel's hold bit is 1, a CPU read leaves the new-data flag set. A CPU write of 0 to the flag's control bit clears it, and a write of 1 never sets it.
- R8: In wide mode, a debug write loads incoming 0 from data bits 15:0 and incoming 1 from bits 31:16 and sets both new-data flags. A debug read returns {outgoing 1, outgoing 0} and sets both ready flags. The channel select is ignored in this mode.
- R9: In 16-bit mode the debug channel select picks one channel, and the other channel's register and flags are left untouched.
- R10: When a debug write and a CPU read that would clear the flag hit the same incoming channel in the same cycle, the flag ends at 1 and the CPU read returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write (1) or read (0) |
| cpu_addr_i | input | 3 | CPU word address |
| cpu_be_i | input | DW/8 | CPU byte enables |
| cpu_wdata_i | input | DW | CPU write data |
| cpu_rdata_o | output | DW | CPU read data, combinational |
| dbg_req_i | input | 1 | Debug access request |
| dbg_we_i | input | 1 | Debug write (1) or read (0) |
| dbg_sel_i | input | 1 | Debug channel select in 16-bit mode |
| dbg_wdata_i | input | 2*DW | Debug write data |
| dbg_rdata_o | output | 2*DW | Debug read data, combinational |
| out_rdy_o | output | 2 | Outgoing ready flags, one per channel |
| in_new_o | output | 2 | Incoming new-data flags, one per channel |

## Verification
Each flag is a single register, and its pin changes one clock after the access that moves it. A flag that is wrong internally therefore shows up on out_rdy_o or in_new_o, and in the control word read, within one cycle of the offending access. A wrong data byte in a mailbox stays hidden until that register is read from its far side, so the sweeps read every register back right after each byte-enable pattern. The collision cycles are driven on purpose, because a wrong priority there only shows as a lost or cleared flag in that single cycle.

// File: rtl/dbg_mbox_pkg.sv
`timescale 1ns/1ps
package dbg_mbox_pkg;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_IN0  = 3'd1;
  localparam logic [AW-1:0] A_OUT0 = 3'd3;
  localparam int unsigned NCH = 2;
  // control bit positions, decoded by software
  localparam int unsigned CB_NEW0  = 0;
  localparam int unsigned CB_RDY0  = 2;
  localparam int unsigned CB_WIDE  = 4;
  localparam int unsigned CB_HOLD0 = 6;
endpackage

// File: rtl/mbox_out_chan.sv
`timescale 1ns/1ps
module mbox_out_chan #(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          rdy_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_o[b*8 +: 8] <= '0;
      else if (wr_i && be_i[b]) data_o[b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  // a fresh message (upper byte committed) outranks a concurrent pickup
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_o <= 1'b1;
    else if (wr_i && be_i[NB-1]) rdy_o <= 1'b0;
    else if (take_i) rdy_o <= 1'b1;
  end
endmodule

// File: rtl/mbox_in_chan.sv
`timescale 1ns/1ps
module mbox_in_chan #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          put_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          new_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else if (put_i) data_o <= pdata_i;
  end

  // set has priority so a message arriving during a read is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) new_o <= 1'b0;
    else if (put_i) new_o <= 1'b1;
    else if (clr_i) new_o <= 1'b0;
  end
endmodule

// File: rtl/dbg_mbox.sv
`timescale 1ns/1ps
module dbg_mbox
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cpu_req_i,
  input  logic            cpu_we_i,
  input  logic [AW-1:0]   cpu_addr_i,
  input  logic [NB-1:0]   cpu_be_i,
  input  logic [DW-1:0]   cpu_wdata_i,
  output logic [DW-1:0]   cpu_rdata_o,
  input  logic            dbg_req_i,
  input  logic            dbg_we_i,
  input  logic            dbg_sel_i,
  input  logic [2*DW-1:0] dbg_wdata_i,
  output logic [2*DW-1:0] dbg_rdata_o,
  output logic [NCH-1:0]  out_rdy_o,
  output logic [NCH-1:0]  in_new_o
);
  logic           cpu_rd, cpu_wr, dbg_rd, dbg_wr, ctrl_wr;
  logic           wide_q;
  logic [NCH-1:0] hold_q;
  logic [DW-1:0]  in_data  [NCH];
  logic [DW-1:0]  out_data [NCH];
  logic [DW-1:0]  ctrl_rd;

  assign cpu_rd  = cpu_req_i && !cpu_we_i;
  assign cpu_wr  = cpu_req_i &&  cpu_we_i;
  assign dbg_rd  = dbg_req_i && !dbg_we_i;
  assign dbg_wr  = dbg_req_i &&  dbg_we_i;
  assign ctrl_wr = cpu_wr && cpu_addr_i == A_CTRL && cpu_be_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b0;
      hold_q <= '0;
    end else if (ctrl_wr) begin
      wide_q <= cpu_wdata_i[CB_WIDE];
      hold_q <= cpu_wdata_i[CB_HOLD0 +: NCH];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] InAddr  = A_IN0  + AW'(c);
    localparam logic [AW-1:0] OutAddr = A_OUT0 + AW'(c);
    logic          hit;
    logic          rd_clr, sw_clr;
    logic [DW-1:0] pdata;

    assign hit    = wide_q || (dbg_sel_i == c[0]);
    assign rd_clr = cpu_rd && cpu_addr_i == InAddr && !hold_q[c];
    assign sw_clr = ctrl_wr && !cpu_wdata_i[CB_NEW0 + c];
    assign pdata  = wide_q ? dbg_wdata_i[c*DW +: DW] : dbg_wdata_i[DW-1:0];

    mbox_in_chan #(.DW(DW)) i_in (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .put_i   (dbg_wr && hit),
      .pdata_i (pdata),
      .clr_i   (rd_clr || sw_clr),
      .data_o  (in_data[c]),
      .new_o   (in_new_o[c])
    );

    mbox_out_chan #(.DW(DW)) i_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cpu_wr && cpu_addr_i == OutAddr),
      .be_i    (cpu_be_i),
      .wdata_i (cpu_wdata_i),
      .take_i  (dbg_rd && hit),
      .data_o  (out_data[c]),
      .rdy_o   (out_rdy_o[c])
    );
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_HOLD0 +: NCH] = hold_q;
    ctrl_rd[CB_WIDE]         = wide_q;
    ctrl_rd[CB_RDY0 +: NCH]  = out_rdy_o;
    ctrl_rd[CB_NEW0 +: NCH]  = in_new_o;
  end

  always_comb begin
    case (cpu_addr_i)
      A_CTRL:          cpu_rdata_o = ctrl_rd;
      A_IN0:           cpu_rdata_o = in_data[0];
      A_IN0 + 3'd1:    cpu_rdata_o = in_data[1];
      A_OUT0:          cpu_rdata_o = out_data[0];
      A_OUT0 + 3'd1:   cpu_rdata_o = out_data[1];
      default:         cpu_rdata_o = '0;
    endcase
  end

  assign dbg_rdata_o = wide_q ? {out_data[1], out_data[0]}
                              : {{DW{1'b0}}, out_data[dbg_sel_i]};
endmodule

// File: rtl/dbg_mbox_chk.sv
`timescale 1ns/1ps
module dbg_mbox_chk
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cpu_req_i,
  input logic            cpu_we_i,
  input logic [AW-1:0]   cpu_addr_i,
  input logic [NB-1:0]   cpu_be_i,
  input logic [1:0]      cpu_flag_bits_i,
  input logic [DW-1:0]   cpu_rdata_o,
  input logic            dbg_req_i,
  input logic            dbg_we_i,
  input logic            dbg_sel_i,
  input logic [NCH-1:0]  out_rdy_o,
  input logic [NCH-1:0]  in_new_o,
  input logic            wide_i,
  input logic [NCH-1:0]  hold_i
);
  logic c_rd, c_wr, d_rd, d_wr, wr_out0;
  assign c_rd    = cpu_req_i && !cpu_we_i;
  assign c_wr    = cpu_req_i &&  cpu_we_i;
  assign d_rd    = dbg_req_i && !dbg_we_i;
  assign d_wr    = dbg_req_i &&  dbg_we_i;
  assign wr_out0 = c_wr && cpu_addr_i == A_OUT0;

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rd && cpu_addr_i == A_CTRL) |-> (cpu_rdata_o[DW-1:8] == '0 && !cpu_rdata_o[5]));

  p_upper_clears_rdy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_out0 && cpu_be_i[NB-1]) |=> !out_rdy_o[0]);

  p_low_keeps_rdy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_out0 && !cpu_be_i[NB-1] && !d_rd) |=> $stable(out_rdy_o[0]));

  p_take_sets_rdy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_rd && !wide_i && !dbg_sel_i && !wr_out0) |=> out_rdy_o[0]);

  p_autoclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rd && cpu_addr_i == A_IN0 && !hold_i[0] && !d_wr) |=> !in_new_o[0]);

  p_hold_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_new_o[0] && hold_i[0] &&
     !(c_wr && cpu_addr_i == A_CTRL && cpu_be_i[0] && !cpu_flag_bits_i[0])) |=> in_new_o[0]);

  p_wide_put_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_wr && wide_i) |=> (in_new_o == 2'b11));

  p_put_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_wr && !wide_i && !dbg_sel_i) |=> in_new_o[0]);
endmodule

bind dbg_mbox dbg_mbox_chk #(.DW(DW)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cpu_req_i       (cpu_req_i),
  .cpu_we_i        (cpu_we_i),
  .cpu_addr_i      (cpu_addr_i),
  .cpu_be_i        (cpu_be_i),
  .cpu_flag_bits_i (cpu_wdata_i[1:0]),
  .cpu_rdata_o     (cpu_rdata_o),
  .dbg_req_i       (dbg_req_i),
  .dbg_we_i        (dbg_we_i),
  .dbg_sel_i       (dbg_sel_i),
  .out_rdy_o       (out_rdy_o),
  .in_new_o        (in_new_o),
  .wide_i          (wide_q),
  .hold_i          (hold_q)
);

// File: tb/test_dbg_mbox.sv
`timescale 1ns/1ps
module test_dbg_mbox;
  localparam int DW = 16;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cpu_req_i = 0, cpu_we_i = 0;
  logic [2:0] cpu_addr_i = '0;
  logic [1:0] cpu_be_i = '0;
  logic [15:0] cpu_wdata_i = '0, cpu_rdata_o;
  logic dbg_req_i = 0, dbg_we_i = 0, dbg_sel_i = 0;
  logic [31:0] dbg_wdata_i = '0, dbg_rdata_o;
  logic [1:0] out_rdy_o, in_new_o;

  always #2.5 clk_i = ~clk_i;

  dbg_mbox #(.DW(DW)) i_dbg_mbox (.*);

  int n_cmp = 0, n_bad = 0;
  logic [15:0] c_rd;
  logic [31:0] d_rd;
  logic [15:0] exp_out [2];
  logic [15:0] exp_in  [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic creq, input logic cwe, input logic [2:0] ca,
                     input logic [1:0] cbe, input logic [15:0] cwd,
                     input logic dreq, input logic dwe, input logic dsel,
                     input logic [31:0] dwd);
    @(negedge clk_i);
    cpu_req_i = creq; cpu_we_i = cwe; cpu_addr_i = ca; cpu_be_i = cbe; cpu_wdata_i = cwd;
    dbg_req_i = dreq; dbg_we_i = dwe; dbg_sel_i = dsel; dbg_wdata_i = dwd;
    #1;
    c_rd = cpu_rdata_o;
    d_rd = dbg_rdata_o;
    @(posedge clk_i);
    #1;
    cpu_req_i = 0; dbg_req_i = 0;
  endtask

  task automatic cwr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    cyc(1, 1, a, be, d, 0, 0, 0, '0);
  endtask
  task automatic crd(input logic [2:0] a);
    cyc(1, 0, a, 2'b00, '0, 0, 0, 0, '0);
  endtask
  task automatic dwr(input logic s, input logic [31:0] d);
    cyc(0, 0, 3'd0, 2'b00, '0, 1, 1, s, d);
  endtask
  task automatic drd(input logic s);
    cyc(0, 0, 3'd0, 2'b00, '0, 1, 0, s, '0);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_out[0] = '0; exp_out[1] = '0; exp_in[0] = '0; exp_in[1] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    crd(3'd0); chk("R1 ctrl", 32'(c_rd), 32'h000C);
    chk("R1 rdy", 32'(out_rdy_o), 32'd3);
    chk("R1 new", 32'(in_new_o), 32'd0);
    for (int a = 1; a <= 4; a++) begin
      crd(3'(a)); chk("R1 mbox", 32'(c_rd), 32'd0);
    end

    // R2 reserved and writable bits
    cwr(3'd0, 2'b11, 16'hFFFF);
    crd(3'd0); chk("R2 all ones", 32'(c_rd), 32'h00DC);
    cwr(3'd0, 2'b10, 16'h0000);
    crd(3'd0); chk("R2 upper byte only", 32'(c_rd), 32'h00DC);
    cwr(3'd0, 2'b11, 16'h0000);
    crd(3'd0); chk("R2 cleared", 32'(c_rd), 32'h000C);

    // R3/R4 sweep over channels and byte enables
    for (int c = 0; c < 2; c++) begin
      for (int be = 0; be < 4; be++) begin
        logic [15:0] d;
        d = 16'((be + 1) * 16'h1111 + c * 16'h0F0F);
        drd(1'(c));
        chk("R4 dbg data", d_rd, {16'h0, exp_out[c]});
        chk("R4 rdy set", 32'(out_rdy_o[c]), 32'd1);
        cwr(3'(3 + c), 2'(be), d);
        if (be[0]) exp_out[c][7:0] = d[7:0];
        if (be[1]) exp_out[c][15:8] = d[15:8];
        chk("R3 rdy after write", 32'(out_rdy_o[c]), 32'(!be[1]));
        crd(3'(3 + c));
        chk("R3 byte merge", 32'(c_rd), 32'(exp_out[c]));
      end
    end

    // R4 collision: CPU word write and debug read together
    cyc(1, 1, 3'd3, 2'b11, 16'h5A5A, 1, 0, 0, '0);
    chk("R4 collision old data", d_rd, {16'h0, exp_out[0]});
    chk("R4 collision rdy", 32'(out_rdy_o[0]), 32'd0);
    exp_out[0] = 16'h5A5A;
    drd(1'b0);
    chk("R4 new data", d_rd, {16'h0, exp_out[0]});
    chk("R4 rdy", 32'(out_rdy_o[0]), 32'd1);

    // R5/R6/R7/R9 per channel, with and without hold
    for (int h = 0; h < 2; h++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] d;
        d = 16'(16'h3000 + c * 16'h0404 + h * 16'h0050);
        cwr(3'd0, 2'b01, h[0] ? 16'h00C0 : 16'h0000);
        dwr(1'(c), {16'hDEAD, d});
        exp_in[c] = d;
        chk("R5 R9 flag", 32'(in_new_o), 32'(1 << c));
        crd(3'(2 - c));
        chk("R9 other untouched", 32'(c_rd), 32'(exp_in[1-c]));
        crd(3'(1 + c));
        chk("R5 cpu data", 32'(c_rd), 32'(d));
        if (h == 0) begin
          chk("R6 autoclear", 32'(in_new_o[c]), 32'd0);
        end else begin
          chk("R7 hold", 32'(in_new_o[c]), 32'd1);
          cwr(3'd0, 2'b01, 16'h00C3);
          chk("R7 write one keeps", 32'(in_new_o[c]), 32'd1);
          cwr(3'd0, 2'b01, 16'h00C0 | 16'(3 & ~(1 << c)));
          chk("R7 write zero clears", 32'(in_new_o[c]), 32'd0);
          cwr(3'd0, 2'b01, 16'h00C3);
          chk("R7 write one no set", 32'(in_new_o), 32'd0);
        end
      end
    end

    // R10 debug write and auto-clearing CPU read in the same cycle
    cwr(3'd0, 2'b01, 16'h0000);
    cyc(1, 0, 3'd1, 2'b00, '0, 1, 1, 0, 32'h0000_7777);
    chk("R10 old data", 32'(c_rd), 32'(exp_in[0]));
    chk("R10 set wins", 32'(in_new_o[0]), 32'd1);
    crd(3'd1);
    chk("R10 new data", 32'(c_rd), 32'h7777);
    chk("R10 then cleared", 32'(in_new_o[0]), 32'd0);

    // R8 wide mode
    cwr(3'd0, 2'b01, 16'h0010);
    cwr(3'd3, 2'b11, 16'h1111);
    cwr(3'd4, 2'b11, 16'h2222);
    chk("R8 rdy cleared", 32'(out_rdy_o), 32'd0);
    drd(1'b1);
    chk("R8 wide read", d_rd, 32'h2222_1111);
    chk("R8 both rdy", 32'(out_rdy_o), 32'd3);
    dwr(1'b1, 32'hBEEF_1234);
    chk("R8 both new", 32'(in_new_o), 32'd3);
    crd(3'd1); chk("R8 in0", 32'(c_rd), 32'h1234);
    crd(3'd2); chk("R8 in1", 32'(c_rd), 32'hBEEF);
    chk("R8 flags cleared", 32'(in_new_o), 32'd0);
    crd(3'd0); chk("R8 ctrl", 32'(c_rd), 32'h001C);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule